// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector

This block holds the replacement state for a set-associative cache with `WAYS` ways and `SETS` sets. Each way of each set owns a single usage flag. A flag reads one while its way is a candidate for eviction. It is cleared to zero when the cache reports a hit on that way or fills it. The tag and data arrays sit outside this block. They report each hit or fill through the touch port. When they must allocate a line, they ask for a victim through the request port.

When a request arrives, the block examines the flag vector of the named set, with any touch to the same set in that cycle already folded in. If at least one flag is one, the lowest-numbered way whose flag is one becomes the victim, and the state does not change. If every flag is zero, the whole set is re-armed to ones and way 0 is the victim. The victim number is registered and appears on the cycle after the request.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset, every flag of every set is one, so the first request to any set returns way 0. `vic_valid` is low while reset is held and on the first cycle after reset.
- R2: A touch (`touch_en` high, with `touch_set` and `touch_way`) clears only the flag of that way in that set. Other ways and other sets are unaffected.
- R3: When the requested set has at least one flag at one, `vic_way` is the lowest-numbered way whose flag is one.
- R4: When every flag of the requested set is zero, all flags of that set become one and `vic_way` is 0.
- R5: When a touch and a request name the same set in the same cycle, the touch is applied before the victim is chosen.
- R6: `vic_valid` is high exactly in the cycle after a cycle with `vic_req` high. `vic_way` keeps its value in cycles that follow no request.
- R7: A request that finds a flag at one leaves the state unchanged, so an immediate repeat request to the same set returns the same way.
- R8: Touching a way whose flag is already zero has no effect on any later victim choice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| touch_en | input | 1 | Hit or fill on the way named below |
| touch_set | input | $clog2(SETS) | Set index of the touch |
| touch_way | input | $clog2(WAYS) | Way number of the touch |
| vic_req | input | 1 | Victim request |
| vic_set | input | $clog2(SETS) | Set index of the victim request |
| vic_valid | output | 1 | Victim way valid, one cycle after `vic_req` |
| vic_way | output | $clog2(WAYS) | Chosen victim way |

## Verification
The flag state cannot be seen directly. A corrupted flag shows up only as a wrong `vic_way` on the next request to that set, one cycle after that request. A fault can therefore stay hidden until that set is asked for a victim. The bench narrows this window by sweeping every flag pattern of every set of a four-way, four-set instance. Each pattern is followed at once by one request and then a repeat request, so every stored flag pattern is exposed within two cycles. Any wrong re-arm appears on that repeat request. A pseudo-random phase mixes touches and requests, including same-set collisions, against a model of the requirements kept in the bench.

// File: rtl/nru_pkg.sv
package nru_pkg;

   // One-hot mask of width n with bit idx set
   function automatic logic [63:0] way_mask(input int unsigned idx);
      logic [63:0] m;
      m = '0;
      m[idx] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/nru_state_array.sv
module nru_state_array #(
   parameter int WAYS = 4,
   parameter int SETS = 8,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic [SET_W-1:0] clr_set,
   input  logic [WAY_W-1:0] clr_way,
   input  logic             arm_en,
   input  logic [SET_W-1:0] arm_set,
   input  logic [SET_W-1:0] rd_set,
   output logic [WAYS-1:0]  rd_vec
);

   logic [WAYS-1:0] flags_q [SETS];

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic [WAYS-1:0] nxt;
      logic            hit_clr;
      logic            hit_arm;

      assign hit_clr = clr_en && (clr_set == SET_W'(s));
      assign hit_arm = arm_en && (arm_set == SET_W'(s));

      always_comb begin
         nxt = flags_q[s];
         if (hit_clr) nxt = nxt & ~nru_pkg::way_mask(32'(clr_way))[WAYS-1:0];
         if (hit_arm) nxt = '1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags_q[s] <= '1;
         else        flags_q[s] <= nxt;
      end
   end

   assign rd_vec = flags_q[rd_set];

endmodule

// File: rtl/nru_pick.sv
module nru_pick #(
   parameter int WAYS = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  vec,
   output logic             any,
   output logic [WAY_W-1:0] way
);

   if (WAYS == 2) begin : g_two
      assign any = |vec;
      assign way = vec[0] ? 1'b0 : 1'b1;
   end else begin : g_many
      always_comb begin
         way = '0;
         for (int i = WAYS - 1; i >= 0; i--) begin
            if (vec[i]) way = WAY_W'(i);
         end
      end
      assign any = |vec;
   end

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
   parameter int WAYS = 4,
   parameter int SETS = 8,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic             vic_req,
   input  logic [SET_W-1:0] vic_set,
   output logic             vic_valid,
   output logic [WAY_W-1:0] vic_way
);

   if (WAYS < 2 || WAYS > 64) begin : g_bad_ways
      $error("nru_victim_sel: WAYS must lie in 2..64");
   end
   if (SETS < 2) begin : g_bad_sets
      $error("nru_victim_sel: SETS must be at least 2");
   end

   logic [WAYS-1:0]  stored_vec;
   logic [WAYS-1:0]  eff_vec;
   logic             any_one;
   logic [WAY_W-1:0] low_way;
   logic             rearm;
   logic [WAY_W-1:0] chosen;
   logic             valid_q;
   logic [WAY_W-1:0] way_q;

   nru_state_array #(.WAYS(WAYS), .SETS(SETS)) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_en  (touch_en),
      .clr_set (touch_set),
      .clr_way (touch_way),
      .arm_en  (rearm),
      .arm_set (vic_set),
      .rd_set  (vic_set),
      .rd_vec  (stored_vec)
   );

   // Same-set touch in this cycle is folded in before the choice
   always_comb begin
      eff_vec = stored_vec;
      if (touch_en && (touch_set == vic_set))
         eff_vec = stored_vec & ~nru_pkg::way_mask(32'(touch_way))[WAYS-1:0];
   end

   nru_pick #(.WAYS(WAYS)) u_pick (
      .vec (eff_vec),
      .any (any_one),
      .way (low_way)
   );

   assign rearm  = vic_req && !any_one;
   assign chosen = any_one ? low_way : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         way_q   <= '0;
      end else begin
         valid_q <= vic_req;
         if (vic_req) way_q <= chosen;
      end
   end

   assign vic_valid = valid_q;
   assign vic_way   = way_q;

endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
   parameter int WAYS = 4,
   parameter int SETS = 8,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             touch_en,
   input logic [SET_W-1:0] touch_set,
   input logic [WAY_W-1:0] touch_way,
   input logic             vic_req,
   input logic [SET_W-1:0] vic_set,
   input logic             vic_valid,
   input logic [WAY_W-1:0] vic_way
);

   logic [WAYS-1:0]  sh_q [SETS];
   logic [WAYS-1:0]  sh_d [SETS];
   logic [WAYS-1:0]  look;
   logic [WAY_W-1:0] pick;
   logic [WAY_W-1:0] exp_q;

   always_comb begin
      for (int s = 0; s < SETS; s++) sh_d[s] = sh_q[s];
      if (touch_en) sh_d[touch_set][touch_way] = 1'b0;
      look = sh_d[vic_set];
      pick = '0;
      for (int i = WAYS - 1; i >= 0; i--) if (look[i]) pick = WAY_W'(i);
      if (vic_req && look == '0) sh_d[vic_set] = '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) sh_q[s] <= '1;
         exp_q <= '0;
      end else begin
         for (int s = 0; s < SETS; s++) sh_q[s] <= sh_d[s];
         if (vic_req) exp_q <= pick;
      end
   end

   a_r6_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      vic_req |=> vic_valid);

   a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !vic_req |=> !vic_valid);

   a_r6_way_held: assert property (@(posedge clk) disable iff (!rst_n)
      !vic_req |=> $stable(vic_way));

   // R3, R5, R7: registered choice matches the shadow flags
   a_r3_lowest_one: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> vic_way == exp_q);

   a_r4_rearm_way0: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_req && look == '0) |=> vic_way == '0);

endmodule

bind nru_victim_sel nru_victim_sel_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (.*);

// File: tb/nru_victim_sel_tb.sv
`timescale 1ns/1ps
module nru_victim_sel_tb;

   localparam int W = 4;
   localparam int S = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       touch_en = 1'b0;
   logic [1:0] touch_set = '0;
   logic [1:0] touch_way = '0;
   logic       vic_req = 1'b0;
   logic [1:0] vic_set = '0;
   logic       vic_valid;
   logic [1:0] vic_way;

   int n_checks = 0;
   int n_fail   = 0;
   logic [W-1:0] model [S];

   always #4 clk = ~clk;

   nru_victim_sel #(.WAYS(W), .SETS(S)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch_en  (touch_en),
      .touch_set (touch_set),
      .touch_way (touch_way),
      .vic_req   (vic_req),
      .vic_set   (vic_set),
      .vic_valid (vic_valid),
      .vic_way   (vic_way)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // One clock: optional touch, optional request; checked at next falling edge
   task automatic step(input logic te, input int ts, input int tw,
                       input logic vr, input int vs, input string tag);
      int exp;
      logic [W-1:0] v;
      exp = 0;
      if (te) model[ts][tw] = 1'b0;
      if (vr) begin
         v = model[vs];
         if (v == '0) model[vs] = '1;
         else for (int i = W - 1; i >= 0; i--) if (v[i]) exp = i;
      end
      touch_en  = te;
      touch_set = 2'(ts);
      touch_way = 2'(tw);
      vic_req   = vr;
      vic_set   = 2'(vs);
      @(posedge clk);
      @(negedge clk);
      touch_en = 1'b0;
      vic_req  = 1'b0;
      check({tag, " valid"}, int'(vic_valid), int'(vr));
      if (vr) check({tag, " way"}, int'(vic_way), exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      for (int s = 0; s < S; s++) model[s] = '1;
      repeat (3) @(posedge clk);
      check("R1 reset valid", int'(vic_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 post-reset valid", int'(vic_valid), 0);

      // R1: fresh sets give way 0
      for (int s = 0; s < S; s++) step(1'b0, 0, 0, 1'b1, s, "R1 fresh set");
      // R2: touch in set 1 does not affect set 2
      step(1'b1, 1, 0, 1'b0, 0, "R2 touch");
      step(1'b0, 0, 0, 1'b1, 2, "R2 other set");
      step(1'b0, 0, 0, 1'b1, 1, "R2 own set");
      // R5: same-cycle touch of way 1 in set 1 skips it
      step(1'b1, 1, 1, 1'b1, 1, "R5 same set");
      // R8: touching a cleared way again changes nothing
      step(1'b1, 1, 0, 1'b0, 0, "R8 retouch");
      step(1'b0, 0, 0, 1'b1, 1, "R8 after retouch");
      // R6: idle cycle keeps way, valid low
      step(1'b0, 0, 0, 1'b0, 0, "R6 idle");
      check("R6 held way", int'(vic_way), 2);

      // Exhaustive sweep of every flag pattern in every set (R3, R4, R7)
      for (int s = 0; s < S; s++) begin
         for (int p = 0; p < (1 << W); p++) begin
            for (int w = 0; w < W; w++) step(1'b1, s, w, 1'b0, 0, "R2 clear");
            step(1'b0, 0, 0, 1'b1, s, "R4 rearm");
            for (int w = 0; w < W; w++)
               if (!p[w]) step(1'b1, s, w, 1'b0, 0, "R2 shape");
            step(1'b0, 0, 0, 1'b1, s, (p == 0) ? "R4 all zero" : "R3 lowest one");
            step(1'b0, 0, 0, 1'b1, s, "R7 repeat");
         end
      end

      // Pseudo-random mix including same-set collisions (R5)
      lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0], int'(lfsr[2:1]), int'(lfsr[4:3]), lfsr[5] | lfsr[6],
              lfsr[7] ? int'(lfsr[2:1]) : int'(lfsr[9:8]),
              (lfsr[0] && lfsr[7]) ? "R5 random" : "R3 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule